// File: doc/BRIEF.md
# Periodic Four-Bit Burst Serializer

This block carries a small parallel word across a single wire. On its own timing, with no request from outside, it takes a snapshot of a parallel input word and sends it as a short burst on one serial line. The burst repeats at a fixed frame rate. Each burst opens with a start pulse that drives the line low for half a bit time. The data bits follow, least significant first, each held at its true level for one full bit time. Between bursts the line rests high. A receiver that runs from the same clock frequency finds the falling edge of the start pulse and then waits one bit time. That lands it in the centre of bit 0.

Every duration is a parameter counted in clock cycles. The defaults assume a 1 MHz clock: 500 cycles of start pulse, 1000 cycles per data bit and a 100000-cycle frame, which gives a 10 Hz update rate. The parameters must satisfy FRAME_CYC > START_CYC + DATA_W*BIT_CYC.

The controller has three named states. **IDLE** holds the line high. On a frame tick it takes transition *T_LAUNCH* to **START**, which loads the input snapshot. **START** drives the line low and leaves through *T_FIRST_BIT* to **DATA** once START_CYC cycles have elapsed. **DATA** presents the current bit. After each BIT_CYC cycles it either takes *T_NEXT_BIT*, staying in DATA and moving to the next bit, or, after the last bit, takes *T_DONE* back to **IDLE**.

Top module: `burst_encoder`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) puts the block in IDLE with line_o high, including when a burst is in progress.
- R2: The start pulse of the first burst begins at the FRAME_CYC-th rising edge after reset is released. Each later burst begins exactly FRAME_CYC edges after the previous one.
- R3: The start pulse drives line_o low for exactly START_CYC clock cycles.
- R4: After the start pulse, line_o carries data bits 0 up to DATA_W-1 in that order. Each bit sits at its true level (1 = high) for exactly BIT_CYC cycles.
- R5: After the last data bit, line_o returns high and stays high until the next start pulse.
- R6: par_i is sampled only at the rising edge where a burst begins. Changes to par_i during a burst do not alter the bits that burst sends.
- R7: Changes to par_i between bursts have no effect on line_o, which stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all durations are counted in its cycles |
| rst_i | input | 1 | Synchronous reset, active high |
| par_i | input | DATA_W | Parallel word, sampled at each burst start |
| line_o | output | 1 | Serial line: idle high, start low, then data bits LSB first |

## Verification
line_o is decoded from registers, so every result appears right after the rising edge that causes it. The bench counts rising edges since reset release and samples at each falling edge. For edge count e, the expected level is derived from e modulo FRAME_CYC: high before the first frame and in the idle tail, low for phase below START_CYC, and otherwise bit (phase-START_CYC)/BIT_CYC of the word captured at the last multiple of FRAME_CYC. The bench changes par_i only at falling edges, after that cycle's check. This keeps the value seen at a launch edge unambiguous. It also lets changes made mid-burst and in the idle gap be judged in the very next sample. After a reset taken in the middle of a burst, the line must be high at the first falling edge that follows.

// File: rtl/burst_encoder_pkg.sv
package burst_encoder_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2
    } enc_state_e;

    function automatic int unsigned width_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/burst_frame_pacer.sv
module burst_frame_pacer #(
    parameter int unsigned FRAME_CYC = 100000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    import burst_encoder_pkg::*;

    localparam int unsigned CW = width_for(FRAME_CYC);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    // R2: frame counter never leaves its range and wraps after a tick
    a_r2_frame_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);
    a_r2_frame_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/burst_dwell_timer.sv
module burst_dwell_timer #(
    parameter int unsigned MAX_CYC = 1000
) (
    input  logic                                              clk_i,
    input  logic                                              restart_i,
    input  logic [burst_encoder_pkg::width_for(MAX_CYC+1)-1:0] limit_i,
    output logic                                              expire_o
);
    import burst_encoder_pkg::*;

    localparam int unsigned TW = width_for(MAX_CYC + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (restart_i) begin
            cnt_q <= '0;
        end else if (!expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = (cnt_q == limit_i - 1'b1);

    // R3/R4: the dwell count stays below the longest duration it may time
    a_r3_dwell_bound: assert property (@(posedge clk_i) disable iff (restart_i)
        cnt_q < TW'(MAX_CYC));

endmodule

// File: rtl/burst_shifter.sv
module burst_shifter #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] par_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] shreg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= '0;
        end else if (load_i) begin
            shreg_q <= par_i;
        end else if (shift_i) begin
            shreg_q <= shreg_q >> 1;
        end
    end

    assign bit_o = shreg_q[0];

    // R6: the snapshot only changes on a load or a shift, never with par_i alone
    a_r6_snapshot_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !shift_i) |=> $stable(shreg_q));

endmodule

// File: rtl/burst_encoder.sv
module burst_encoder #(
    parameter int unsigned DATA_W    = 4,
    parameter int unsigned START_CYC = 500,
    parameter int unsigned BIT_CYC   = 1000,
    parameter int unsigned FRAME_CYC = 100000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] par_i,
    output logic              line_o
);
    import burst_encoder_pkg::*;

    localparam int unsigned MAX_DWELL = (START_CYC > BIT_CYC) ? START_CYC : BIT_CYC;
    localparam int unsigned TW        = width_for(MAX_DWELL + 1);
    localparam int unsigned IW        = width_for(DATA_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    enc_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          frame_tick;
    logic          dwell_expire;
    logic          dwell_restart;
    logic [TW-1:0] dwell_limit;
    logic          snap_load;
    logic          snap_shift;
    logic          cur_bit;

    burst_frame_pacer #(.FRAME_CYC(FRAME_CYC)) i_pacer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (frame_tick)
    );

    burst_dwell_timer #(.MAX_CYC(MAX_DWELL)) i_dwell (
        .clk_i     (clk_i),
        .restart_i (dwell_restart),
        .limit_i   (dwell_limit),
        .expire_o  (dwell_expire)
    );

    burst_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (snap_load),
        .shift_i (snap_shift),
        .par_i   (par_i),
        .bit_o   (cur_bit)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state and transition strobes
    always_comb begin
        state_d       = state_q;
        idx_d         = idx_q;
        snap_load     = 1'b0;
        snap_shift    = 1'b0;
        dwell_restart = rst_i;
        dwell_limit   = TW'(BIT_CYC);
        unique case (state_q)
            ST_IDLE: begin
                dwell_restart = 1'b1;
                if (frame_tick) begin            // T_LAUNCH
                    state_d   = ST_START;
                    snap_load = 1'b1;
                    idx_d     = '0;
                end
            end
            ST_START: begin
                dwell_limit = TW'(START_CYC);
                if (dwell_expire) begin          // T_FIRST_BIT
                    state_d       = ST_DATA;
                    dwell_restart = 1'b1;
                end
            end
            ST_DATA: begin
                if (dwell_expire) begin
                    dwell_restart = 1'b1;
                    if (idx_q == LAST_IDX) begin // T_DONE
                        state_d = ST_IDLE;
                    end else begin               // T_NEXT_BIT
                        idx_d      = idx_q + 1'b1;
                        snap_shift = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = cur_bit;
            default:  line_o = 1'b1;
        endcase
    end

    // R1: reset leaves the line idle high
    a_r1_reset_idle: assert property (@(posedge clk_i)
        rst_i |=> (line_o && state_q == ST_IDLE));

    // R2: a frame tick seen in IDLE launches a burst on the next edge
    a_r2_launch: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && frame_tick) |=> (state_q == ST_START && !line_o));

    // R3: the start pulse persists until its dwell expires
    a_r3_start_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_START && !dwell_expire) |=> (state_q == ST_START));

    // R4: the bit index never passes the last data bit
    a_r4_idx_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        idx_q <= LAST_IDX);

    // R5: after the last bit expires the line is back high in IDLE
    a_r5_done_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DATA && idx_q == LAST_IDX && dwell_expire)
            |=> (state_q == ST_IDLE && line_o));

endmodule

// File: tb/test_burst_encoder.sv
module test_burst_encoder;

    localparam int DW    = 4;
    localparam int START = 3;
    localparam int BITC  = 5;
    localparam int FRAME = 40;
    localparam int NV    = 6;

    // {mid-burst disturbance, word to send}
    localparam logic [7:0] VEC [0:NV-1] = '{
        8'h0_A, 8'hF_5, 8'h0_F, 8'hF_0, 8'h6_9, 8'h9_6
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] par = '0;
    logic          line;

    int            edges = 0;
    logic [DW-1:0] lat = '0;
    int            vi = 0;
    int            n_run = 0;
    int            n_fail = 0;

    always #5 clk = ~clk;

    burst_encoder #(
        .DATA_W(DW), .START_CYC(START), .BIT_CYC(BITC), .FRAME_CYC(FRAME)
    ) i_burst_encoder (
        .clk_i(clk), .rst_i(rst), .par_i(par), .line_o(line)
    );

    always_ff @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    task automatic check(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s edge=%0d line=%b expected=%b", req, edges, got, exp);
        end
    endtask

    // compare line against the model for the current edge count
    task automatic check_cycle();
        int   p;
        logic exp;
        string req;
        p = edges % FRAME;
        if (edges >= FRAME && p == 0) lat = par;
        if (edges < FRAME) begin
            exp = 1'b1; req = "R2 pre-first-burst";
        end else if (p < START) begin
            exp = 1'b0; req = "R3 start pulse";
        end else if (p < START + DW*BITC) begin
            exp = lat[(p-START)/BITC]; req = "R4 R6 data bit";
        end else begin
            exp = 1'b1; req = "R5 R7 idle tail";
        end
        if (p == 0 && edges >= FRAME) req = "R2 launch edge";
        check(req, line, exp);
    endtask

    // drive par_i according to the frame phase, after the check
    task automatic drive_cycle();
        int p;
        p = edges % FRAME;
        if (p == FRAME - 1) begin
            par = VEC[vi][3:0];
            vi  = (vi + 1) % NV;
        end else if (p == START + BITC + 1) begin
            par = VEC[(vi + NV - 1) % NV][7:4] ^ par;   // R6 disturbance
        end else if (p == START + DW*BITC + 3) begin
            par = ~par;                                  // R7 disturbance
        end
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check_cycle();
            drive_cycle();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset line", line, 1'b1);
        par = 4'hC;
        @(negedge clk);
        check("R1 reset ignores input", line, 1'b1);
        rst = 1'b0;

        // table walk: every vector launched in turn, with disturbances
        run(FRAME * (NV + 1));

        // R1: reset taken in the middle of a data bit
        while ((edges % FRAME) != START + BITC + 2) run(1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-burst", line, 1'b1);
        @(negedge clk);
        check("R1 reset held", line, 1'b1);
        rst = 1'b0;
        vi  = 0;

        // R2: restart timing measured from the new release
        run(FRAME * 3);

        // R4: boundary words all ones and all zeros
        while ((edges % FRAME) != FRAME - 2) run(1);
        @(negedge clk); check_cycle(); par = 4'hF;
        run(FRAME - 1);
        @(negedge clk); check_cycle(); par = 4'h0;
        run(FRAME);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule